// File: doc/BRIEF.md
# Background Scrub Sequencer for SECDED Memory

This block sets the pace of background scrubbing in a word-organised memory protected by a single-error-correct, double-error-detect code. An address pointer walks the array one word at a time. For each word the block first pulls an active-low warning line (`busy_n_o`) so that the host can hold off its own accesses. After a programmable lead time it pulls an active-low strobe (`scrub_n_o`) for the read-correct-writeback of the word at `scrub_addr_o`. The pointer then moves to the next word.

There are two ways to start a scrub. In auto mode an internal power-of-two timer requests one scrub per period. A request that arrives while a scrub is still running is queued, so it is not dropped. In command mode an external active-low strobe starts each scrub, and the rate and lead settings are ignored. A bypass input stops new scrubs from starting. The code datapath and the storage array are outside this block. All timing is counted in cycles of `clk_i`, one cycle being the unit of 50 ns at the nominal 20 MHz. The command strobe must already be synchronous to `clk_i`.

Top module: `scrub_sequencer`

## Requirements
- R1: After a synchronous reset, `busy_n_o`=1, `scrub_n_o`=1 and `scrub_addr_o`=0.
- R2: In auto mode (`slave_mode_i`=0, `bypass_i`=0) the internal timer issues one scrub request every 2^n clock cycles, where n is the value of `rate_code_i` (n=0 gives one request per cycle). An idle block begins serving a request in the cycle after that request.
- R3: Each auto scrub first holds `busy_n_o`=0 with `scrub_n_o`=1 for m cycles, where m is the value of `lead_code_i`. When m=0, both lines fall in the same cycle.
- R4: In auto mode `scrub_n_o` stays low for exactly 5 cycles. `busy_n_o` is low whenever `scrub_n_o` is low, and it rises in the cycle after the strobe ends.
- R5: `scrub_addr_o` does not change while a scrub is in progress. It advances by one when the scrub ends, and it wraps from the last address to 0.
- R6: Requests that arrive while a scrub is in progress are counted, up to a maximum of 2^PEND_W−1, and served back to back. Requests beyond that count are dropped. The count is cleared while auto mode is not active.
- R7: In command mode (`slave_mode_i`=1), `scrub_cmd_n_i`=0 seen while idle starts a scrub in the next cycle. Both lines then stay low until the cycle after `scrub_cmd_n_i` returns to 1, and the pointer advances at that point. `rate_code_i` and `lead_code_i` have no effect in this mode.
- R8: While `bypass_i`=1 no new scrub starts in either mode. A scrub already in progress runs to its end.
- R9: A reset asserted in the middle of a scrub returns the block to the R1 state in the next cycle. It also clears queued requests and the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one tick per time unit |
| rst_i | input | 1 | Synchronous reset, active high |
| slave_mode_i | input | 1 | 1 selects command mode, 0 selects auto mode |
| bypass_i | input | 1 | 1 blocks the start of new scrubs |
| rate_code_i | input | RATE_W | Scrub period code n, period of 2^n cycles |
| lead_code_i | input | LEAD_W | Warning lead code m, lead of m cycles |
| scrub_cmd_n_i | input | 1 | Active-low external scrub command |
| busy_n_o | output | 1 | Active-low warning and busy line |
| scrub_n_o | output | 1 | Active-low scrub strobe |
| scrub_addr_o | output | ADDR_W | Word currently or next to be scrubbed |

## Verification
The hardest condition to reach is a saturated request queue that is then drained. This needs timer requests arriving faster than scrubs can finish, followed by a switch out of auto mode or a bypass while requests are still queued. The stimulus selects the fastest rate code together with a non-zero lead, which fills the queue to its limit within a few scrubs. It then asserts bypass in the middle of a scrub and afterwards releases it. A seeded random phase also toggles mode, bypass and the command strobe at arbitrary points inside warning and strobe windows. Every cycle is compared with a reference model kept in the bench.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARN  = 2'd1,
        ST_SCRUB = 2'd2,
        ST_CMD   = 2'd3
    } scrub_state_e;

    localparam int SCRUB_CYCLES = 5;
endpackage

// File: rtl/scrub_rate_timer.sv
module scrub_rate_timer #(
    parameter int RATE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [RATE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int CNT_W = 2 ** RATE_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit  = (CNT_W'(1) << code_i) - CNT_W'(1);
        tick_o = en_i && (cnt_q >= limit);
        cnt_d  = cnt_q + CNT_W'(1);
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/scrub_addr_ptr.sv
module scrub_addr_ptr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv_i) begin
            ptr_d = ptr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign addr_o = ptr_q;
endmodule

// File: rtl/scrub_sequencer.sv
module scrub_sequencer
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RATE_W = 4,
    parameter int LEAD_W = 4,
    parameter int PEND_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              slave_mode_i,
    input  logic              bypass_i,
    input  logic [RATE_W-1:0] rate_code_i,
    input  logic [LEAD_W-1:0] lead_code_i,
    input  logic              scrub_cmd_n_i,
    output logic              busy_n_o,
    output logic              scrub_n_o,
    output logic [ADDR_W-1:0] scrub_addr_o
);
    localparam int PH_W = (LEAD_W > 3) ? LEAD_W : 3;
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    typedef struct packed {
        scrub_state_e      st;
        logic [PH_W-1:0]   ph;
        logic [PEND_W-1:0] pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic auto_en;
    logic tick;
    logic take;
    logic advance;

    scrub_rate_timer #(.RATE_W(RATE_W)) timer_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (auto_en),
        .code_i (rate_code_i),
        .tick_o (tick)
    );

    scrub_addr_ptr #(.ADDR_W(ADDR_W)) ptr_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .adv_i  (advance),
        .addr_o (scrub_addr_o)
    );

    always_comb begin
        auto_en = !slave_mode_i && !bypass_i;
        ctl_d   = ctl_q;
        take    = 1'b0;
        advance = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (slave_mode_i && !bypass_i && !scrub_cmd_n_i) begin
                    ctl_d.st = ST_CMD;
                end else if (auto_en && (tick || ctl_q.pend != '0)) begin
                    take = 1'b1;
                    if (lead_code_i == '0) begin
                        ctl_d.st = ST_SCRUB;
                        ctl_d.ph = PH_W'(SCRUB_CYCLES - 1);
                    end else begin
                        ctl_d.st = ST_WARN;
                        ctl_d.ph = PH_W'(lead_code_i) - PH_W'(1);
                    end
                end
            end
            ST_WARN: begin
                if (ctl_q.ph == '0) begin
                    ctl_d.st = ST_SCRUB;
                    ctl_d.ph = PH_W'(SCRUB_CYCLES - 1);
                end else begin
                    ctl_d.ph = ctl_q.ph - PH_W'(1);
                end
            end
            ST_SCRUB: begin
                if (ctl_q.ph == '0) begin
                    ctl_d.st = ST_IDLE;
                    advance  = 1'b1;
                end else begin
                    ctl_d.ph = ctl_q.ph - PH_W'(1);
                end
            end
            ST_CMD: begin
                if (scrub_cmd_n_i) begin
                    ctl_d.st = ST_IDLE;
                    advance  = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        // request queue: a tick served directly in the same cycle never enters it
        if (!auto_en) begin
            ctl_d.pend = '0;
        end else if (take && !tick) begin
            ctl_d.pend = ctl_q.pend - PEND_W'(1);
        end else if (!take && tick && ctl_q.pend != PEND_MAX) begin
            ctl_d.pend = ctl_q.pend + PEND_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '{st: ST_IDLE, ph: '0, pend: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_n_o  = (ctl_q.st == ST_IDLE);
    assign scrub_n_o = !((ctl_q.st == ST_SCRUB) || (ctl_q.st == ST_CMD));
endmodule

// File: rtl/scrub_sequencer_chk.sv
module scrub_sequencer_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              bypass_i,
    input logic              busy_n_o,
    input logic              scrub_n_o,
    input logic [ADDR_W-1:0] scrub_addr_o
);
    // R4: strobe never active without the busy line
    a_r4_strobe_inside_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        !scrub_n_o |-> !busy_n_o);

    // R5: pointer frozen across consecutive busy cycles
    a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_n_o && !$past(busy_n_o) && !$past(rst_i)) |-> $stable(scrub_addr_o));

    // R5: pointer moves by one when a scrub finishes
    a_r5_addr_step: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(busy_n_o) && !$past(rst_i)) |-> (scrub_addr_o == $past(scrub_addr_o) + ADDR_W'(1)));

    // R8: bypass keeps an idle block idle
    a_r8_bypass_holds_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (bypass_i && busy_n_o) |=> busy_n_o);
endmodule

bind scrub_sequencer scrub_sequencer_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bypass_i     (bypass_i),
    .busy_n_o     (busy_n_o),
    .scrub_n_o    (scrub_n_o),
    .scrub_addr_o (scrub_addr_o)
);

// File: tb/scrub_sequencer_tb_top.sv
module scrub_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int RATE_W     = 4;
    localparam int LEAD_W     = 4;
    localparam int PEND_W     = 3;
    localparam int PEND_MAX   = (1 << PEND_W) - 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              slave_mode;
    logic              bypass;
    logic [RATE_W-1:0] rate_code;
    logic [LEAD_W-1:0] lead_code;
    logic              cmd_n;
    logic              busy_n;
    logic              scrub_n;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 idle, 1 warning, 2 strobe (auto), 3 strobe (command)
    int m_st, m_left, m_pend, m_tmr, m_ptr;

    scrub_sequencer #(
        .ADDR_W(ADDR_W), .RATE_W(RATE_W), .LEAD_W(LEAD_W), .PEND_W(PEND_W)
    ) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .slave_mode_i (slave_mode),
        .bypass_i     (bypass),
        .rate_code_i  (rate_code),
        .lead_code_i  (lead_code),
        .scrub_cmd_n_i(cmd_n),
        .busy_n_o     (busy_n),
        .scrub_n_o    (scrub_n),
        .scrub_addr_o (addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic exp_busy_n();
        return (m_st == 0);
    endfunction

    function automatic logic exp_scrub_n();
        return !(m_st == 2 || m_st == 3);
    endfunction

    // advance the model across one rising edge using the inputs now driven
    task automatic model_step();
        bit en, tick, take;
        if (rst) begin
            m_st = 0; m_left = 0; m_pend = 0; m_tmr = 0; m_ptr = 0;
            return;
        end
        en   = !slave_mode && !bypass;
        tick = en && (m_tmr >= (1 << rate_code) - 1);
        take = 0;
        case (m_st)
            0: begin
                if (slave_mode && !bypass && !cmd_n) m_st = 3;
                else if (en && (tick || m_pend > 0)) begin
                    take = 1;
                    if (lead_code == 0) begin m_st = 2; m_left = 5; end
                    else begin m_st = 1; m_left = int'(lead_code); end
                end
            end
            1: begin
                m_left--;
                if (m_left == 0) begin m_st = 2; m_left = 5; end
            end
            2: begin
                m_left--;
                if (m_left == 0) begin m_st = 0; m_ptr = (m_ptr + 1) % (1 << ADDR_W); end
            end
            default: begin
                if (cmd_n) begin m_st = 0; m_ptr = (m_ptr + 1) % (1 << ADDR_W); end
            end
        endcase
        if (!en) m_pend = 0;
        else if (take && !tick) m_pend--;
        else if (!take && tick && m_pend < PEND_MAX) m_pend++;
        m_tmr = (!en || tick) ? 0 : m_tmr + 1;
    endtask

    task automatic compare(input string req);
        checks++;
        if (busy_n !== exp_busy_n() || scrub_n !== exp_scrub_n() || addr !== ADDR_W'(m_ptr)) begin
            errors++;
            $display("FAIL %s t=%0t busy_n/scrub_n/addr actual %b/%b/%0d expected %b/%b/%0d",
                     req, $time, busy_n, scrub_n, addr, exp_busy_n(), exp_scrub_n(), m_ptr);
        end
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(negedge clk);
            compare(req);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5C2B_0017));
        rst = 1'b1; slave_mode = 1'b0; bypass = 1'b0;
        rate_code = 4'd3; lead_code = 4'd0; cmd_n = 1'b1;
        run(3, "R1");
        checks++;
        if (busy_n !== 1'b1 || scrub_n !== 1'b1 || addr !== '0) begin
            errors++;
            $display("FAIL R1 reset state actual %b/%b/%0d expected 1/1/0", busy_n, scrub_n, addr);
        end
        rst = 1'b0;

        rate_code = 4'd3; lead_code = 4'd0; run(60,  "R2");
        rate_code = 4'd4; lead_code = 4'd5; run(90,  "R3");
        rate_code = 4'd5; lead_code = 4'd1; run(90,  "R4");
        rate_code = 4'd3; lead_code = 4'd0; run(300, "R5");
        rate_code = 4'd0; lead_code = 4'd2; run(120, "R6");

        // bypass raised with requests queued, mid-scrub, then released
        bypass = 1'b1; run(60, "R8");
        bypass = 1'b0; run(40, "R6");

        // command mode, rate and lead settings scrambled throughout
        slave_mode = 1'b1;
        for (int k = 0; k < 40; k++) begin
            rate_code = RATE_W'($urandom);
            lead_code = LEAD_W'($urandom);
            cmd_n = 1'b0; run(1 + ($urandom % 8), "R7");
            cmd_n = 1'b1; run(1 + ($urandom % 6), "R7");
        end
        bypass = 1'b1; cmd_n = 1'b0; run(20, "R8");
        bypass = 1'b0; cmd_n = 1'b1; run(3, "R7");

        // reset mid-scrub
        slave_mode = 1'b0; rate_code = 4'd2; lead_code = 4'd1;
        run(30, "R9");
        rst = 1'b1; run(1, "R9");
        rst = 1'b0; run(40, "R9");

        // seeded random mix of everything
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 50 == 0) slave_mode = ~slave_mode;
            if ($urandom % 40 == 0) bypass = ($urandom % 4 == 0);
            if ($urandom % 30 == 0) rate_code = RATE_W'($urandom % 6);
            if ($urandom % 30 == 0) lead_code = LEAD_W'($urandom);
            if ($urandom % 5 == 0)  cmd_n = ~cmd_n;
            rst = ($urandom % 700 == 0);
            run(1, "R6");
        end
        rst = 1'b0;
        finish_run();
    end
endmodule